// File: doc/BRIEF.md
# Virtual Address Region Access Checker

This block sits behind a processor's load/store port. Each cycle it can accept one 32-bit virtual address together with the privilege level of the access. It decides which fixed region of the virtual space the address falls in and whether the current privilege level may reach that region. For regions that are not translated, it also produces the 29-bit physical address. It also reports whether the region is cacheable and whether the access must go to the translation lookaside buffer. The TLB, page-size handling, ASID matching and the caches are not part of this block.

In privileged mode the 4 GB space falls into five regions, keyed on the top three address bits. In user mode, code may reach only the lower half of the space, plus two small windows in the top region. Each window is opened by its own control input. Everything else seen from user mode is an address error. The verdict is registered in one valid/ready stage, and a stalled consumer holds the stage.

Top module: `vaddr_region_check`

## Requirements
- R1: In privileged mode, `out_region` is 0 for 0x00000000–0x7FFFFFFF, 1 for 0x80000000–0x9FFFFFFF, 2 for 0xA0000000–0xBFFFFFFF, 3 for 0xC0000000–0xDFFFFFFF and 4 for 0xE0000000–0xFFFFFFFF. A privileged access never raises `out_addr_err`.
- R2: `out_cacheable` is 1 exactly when there is no error and the region code is 0, 1 or 3.
- R3: In user mode, 0x00000000–0x7FFFFFFF gives region code 0 with no error.
- R4: In user mode, 0xE0000000–0xE3FFFFFF gives region code 5 with no error when `cfg_sq_lock` is 0. When `cfg_sq_lock` is 1, the same range is an error.
- R5: In user mode, 0xE5000000–0xE5FFFFFF gives region code 6 with no error when `cfg_ocm_user` is 1. When `cfg_ocm_user` is 0, the same range is an error.
- R6: In user mode, every other address raises `out_addr_err` with region code 7. This covers 0x80000000–0xDFFFFFFF, 0xE4000000–0xE4FFFFFF, 0xE6000000–0xFFFFFFFF and any closed window.
- R7: `out_xlate` is 1 exactly when `cfg_xlate_en` is 1, there is no error and the region code is 0 or 3.
- R8: When there is no error and `out_xlate` is 0, `out_paddr` equals the low 29 bits of the virtual address. When `out_xlate` is 1, `out_paddr` is 0.
- R9: When `out_addr_err` is 1, `out_cacheable`, `out_xlate` and `out_paddr` are all 0 and `out_region` is 7.
- R10: An address accepted on a clock edge (`in_valid` and `in_ready` both high) appears with `out_valid` high after that same edge.
- R11: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all outputs hold their values. `in_ready` equals `!out_valid || out_ready`.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address request valid |
| in_ready | output | 1 | Stage can take a request |
| in_vaddr | input | 32 | Virtual address |
| in_priv | input | 1 | 1 = privileged access, 0 = user access |
| cfg_xlate_en | input | 1 | Address translation enabled |
| cfg_sq_lock | input | 1 | 1 closes the user store-queue window |
| cfg_ocm_user | input | 1 | 1 opens the user on-chip memory window |
| out_valid | output | 1 | Verdict valid |
| out_ready | input | 1 | Consumer takes the verdict |
| out_region | output | 3 | Region code (see R1, R3–R6) |
| out_cacheable | output | 1 | Region is cacheable |
| out_xlate | output | 1 | Access needs the TLB |
| out_addr_err | output | 1 | Access is illegal for this privilege level |
| out_paddr | output | 29 | Physical address for untranslated regions |

## Verification
The only state is the output register, so a fault shows up the cycle after the handshake that loaded it. A wrong decode shows as a bad region code or error flag on the next `out_valid` cycle. A register that fails to load or hold shows as a verdict that changes during a stall, or as a stale verdict after a new accept. The bench's reference model predicts every output on every clock, so the first wrong cycle is caught where it happens.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  localparam int VA_W = 32;
  localparam int PA_W = 29;

  typedef enum logic [2:0] {
    SEG_LOW       = 3'd0,
    SEG_DIRECT_C  = 3'd1,
    SEG_DIRECT_U  = 3'd2,
    SEG_MAPPED_HI = 3'd3,
    SEG_CTRL      = 3'd4,
    SEG_USER_SQ   = 3'd5,
    SEG_USER_OCM  = 3'd6,
    SEG_NONE      = 3'd7
  } seg_e;

  typedef struct packed {
    seg_e            seg;
    logic            cache;
    logic            xlate;
    logic            err;
    logic [PA_W-1:0] paddr;
  } verdict_t;

  // privileged region from the three top address bits
  function automatic seg_e f_priv_seg(input logic [2:0] top3);
    case (top3)
      3'b100:  f_priv_seg = SEG_DIRECT_C;
      3'b101:  f_priv_seg = SEG_DIRECT_U;
      3'b110:  f_priv_seg = SEG_MAPPED_HI;
      3'b111:  f_priv_seg = SEG_CTRL;
      default: f_priv_seg = SEG_LOW;
    endcase
  endfunction

  function automatic logic f_seg_cacheable(input seg_e s);
    f_seg_cacheable = (s == SEG_LOW) || (s == SEG_DIRECT_C) || (s == SEG_MAPPED_HI);
  endfunction

  function automatic logic f_seg_mapped(input seg_e s);
    f_seg_mapped = (s == SEG_LOW) || (s == SEG_MAPPED_HI);
  endfunction

  // address inside an aligned window of 2**lg bytes starting at base
  function automatic logic f_in_window(input logic [VA_W-1:0] va,
                                       input logic [VA_W-1:0] base,
                                       input int unsigned lg);
    f_in_window = ((va ^ base) >> lg) == '0;
  endfunction
endpackage

// File: rtl/vrc_decode.sv
module vrc_decode
  import vrc_pkg::*;
#(
  parameter logic [VA_W-1:0] SQ_BASE  = 32'hE000_0000,
  parameter int unsigned     SQ_LG    = 26,
  parameter logic [VA_W-1:0] OCM_BASE = 32'hE500_0000,
  parameter int unsigned     OCM_LG   = 24
) (
  input  logic [VA_W-1:0] vaddr,
  output seg_e            priv_seg,
  output logic            is_low,
  output logic            hit_sq,
  output logic            hit_ocm
);
  assign priv_seg = f_priv_seg(vaddr[VA_W-1 -: 3]);
  assign is_low   = ~vaddr[VA_W-1];
  assign hit_sq   = f_in_window(vaddr, SQ_BASE, SQ_LG);
  assign hit_ocm  = f_in_window(vaddr, OCM_BASE, OCM_LG);
endmodule

// File: rtl/vrc_policy.sv
module vrc_policy
  import vrc_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic            priv,
  input  logic            xlate_en,
  input  logic            sq_lock,
  input  logic            ocm_user,
  input  seg_e            priv_seg,
  input  logic            is_low,
  input  logic            hit_sq,
  input  logic            hit_ocm,
  output verdict_t        verdict,
  output logic            user_blocked
);
  seg_e seg_sel;
  logic sq_open, ocm_open;

  assign sq_open      = hit_sq && !sq_lock;
  assign ocm_open     = hit_ocm && ocm_user;
  assign user_blocked = !priv && !is_low && !sq_open && !ocm_open;

  always_comb begin
    if (priv)          seg_sel = priv_seg;
    else if (is_low)   seg_sel = SEG_LOW;
    else if (sq_open)  seg_sel = SEG_USER_SQ;
    else if (ocm_open) seg_sel = SEG_USER_OCM;
    else               seg_sel = SEG_NONE;
  end

  always_comb begin
    verdict       = '0;
    verdict.seg   = seg_sel;
    verdict.err   = user_blocked;
    if (!user_blocked) begin
      verdict.cache = f_seg_cacheable(seg_sel);
      verdict.xlate = xlate_en && f_seg_mapped(seg_sel);
      verdict.paddr = verdict.xlate ? '0 : vaddr[PA_W-1:0];
    end
  end
endmodule

// File: rtl/vrc_stage.sv
module vrc_stage
  import vrc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  verdict_t d,
  output logic     out_valid,
  input  logic     out_ready,
  output verdict_t q,
  output logic     accept
);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      q         <= d;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vaddr_region_check.sv
module vaddr_region_check
  import vrc_pkg::*;
#(
  parameter logic [VA_W-1:0] SQ_BASE  = 32'hE000_0000,
  parameter int unsigned     SQ_LG    = 26,
  parameter logic [VA_W-1:0] OCM_BASE = 32'hE500_0000,
  parameter int unsigned     OCM_LG   = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VA_W-1:0] in_vaddr,
  input  logic            in_priv,
  input  logic            cfg_xlate_en,
  input  logic            cfg_sq_lock,
  input  logic            cfg_ocm_user,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2:0]      out_region,
  output logic            out_cacheable,
  output logic            out_xlate,
  output logic            out_addr_err,
  output logic [PA_W-1:0] out_paddr
);
  seg_e     priv_seg;
  logic     is_low, hit_sq, hit_ocm;
  verdict_t verdict_d, verdict_q;
  logic     user_blocked;
  logic     accept;

  vrc_decode #(
    .SQ_BASE(SQ_BASE), .SQ_LG(SQ_LG), .OCM_BASE(OCM_BASE), .OCM_LG(OCM_LG)
  ) u_decode (
    .vaddr(in_vaddr), .priv_seg(priv_seg), .is_low(is_low),
    .hit_sq(hit_sq), .hit_ocm(hit_ocm)
  );

  vrc_policy u_policy (
    .vaddr(in_vaddr), .priv(in_priv), .xlate_en(cfg_xlate_en),
    .sq_lock(cfg_sq_lock), .ocm_user(cfg_ocm_user),
    .priv_seg(priv_seg), .is_low(is_low), .hit_sq(hit_sq), .hit_ocm(hit_ocm),
    .verdict(verdict_d), .user_blocked(user_blocked)
  );

  vrc_stage u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d(verdict_d), .out_valid(out_valid), .out_ready(out_ready),
    .q(verdict_q), .accept(accept)
  );

  assign out_region    = verdict_q.seg;
  assign out_cacheable = verdict_q.cache;
  assign out_xlate     = verdict_q.xlate;
  assign out_addr_err  = verdict_q.err;
  assign out_paddr     = verdict_q.paddr;
endmodule

// File: rtl/vrc_checker.sv
module vrc_checker #(
  parameter int VA_W = 32,
  parameter int PA_W = 29
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [VA_W-1:0] in_vaddr,
  input logic            in_priv,
  input logic            out_valid,
  input logic            out_ready,
  input logic [2:0]      out_region,
  input logic            out_cacheable,
  input logic            out_xlate,
  input logic            out_addr_err,
  input logic [PA_W-1:0] out_paddr,
  input logic            accept
);
  logic [VA_W-1:0] cap_vaddr;
  logic            cap_priv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_vaddr <= '0;
      cap_priv  <= 1'b0;
    end else if (in_valid && in_ready) begin
      cap_vaddr <= in_vaddr;
      cap_priv  <= in_priv;
    end
  end

  p_priv_noerr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_priv |-> !out_addr_err && out_region <= 3'd4);

  p_user_regions_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cap_priv |-> (out_region == 3'd0 || out_region >= 3'd5));

  p_err_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_addr_err |->
      !out_cacheable && !out_xlate && out_paddr == '0 && out_region == 3'd7);

  p_direct_paddr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_addr_err && !out_xlate |-> out_paddr == cap_vaddr[PA_W-1:0]);

  p_xlate_mapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_xlate |-> (out_region == 3'd0 || out_region == 3'd3));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_region) &&
      $stable(out_paddr) && $stable(out_addr_err) && $stable(out_xlate) &&
      $stable(out_cacheable));

  p_stall_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
endmodule

bind vaddr_region_check vrc_checker #(.VA_W(vrc_pkg::VA_W), .PA_W(vrc_pkg::PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_vaddr(in_vaddr), .in_priv(in_priv), .out_valid(out_valid),
  .out_ready(out_ready), .out_region(out_region), .out_cacheable(out_cacheable),
  .out_xlate(out_xlate), .out_addr_err(out_addr_err), .out_paddr(out_paddr),
  .accept(accept)
);

// File: tb/vaddr_region_check_bench.sv
module vaddr_region_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_vaddr = '0;
  logic        in_priv = 1'b0;
  logic        cfg_xlate_en = 1'b0, cfg_sq_lock = 1'b0, cfg_ocm_user = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_region;
  logic        out_cacheable, out_xlate, out_addr_err;
  logic [28:0] out_paddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  vaddr_region_check u_vaddr_region_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_vaddr(in_vaddr), .in_priv(in_priv), .cfg_xlate_en(cfg_xlate_en),
    .cfg_sq_lock(cfg_sq_lock), .cfg_ocm_user(cfg_ocm_user),
    .out_valid(out_valid), .out_ready(out_ready), .out_region(out_region),
    .out_cacheable(out_cacheable), .out_xlate(out_xlate),
    .out_addr_err(out_addr_err), .out_paddr(out_paddr)
  );

  // reference model state: what the outputs must show after the next edge
  int          m_valid;
  int          m_region, m_cache, m_xlate, m_err;
  longint      m_paddr;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural model from the requirements, on plain unsigned ranges
  task automatic predict(input longint va, input int priv, input int xen,
                         input int sqlock, input int ocm);
    m_err = 0;
    if (priv != 0) begin                                    // R1
      if (va < 64'h8000_0000)      m_region = 0;
      else if (va < 64'hA000_0000) m_region = 1;
      else if (va < 64'hC000_0000) m_region = 2;
      else if (va < 64'hE000_0000) m_region = 3;
      else                         m_region = 4;
    end else if (va < 64'h8000_0000) m_region = 0;           // R3
    else if (va >= 64'hE000_0000 && va < 64'hE400_0000 && sqlock == 0)
      m_region = 5;                                         // R4
    else if (va >= 64'hE500_0000 && va < 64'hE600_0000 && ocm != 0)
      m_region = 6;                                         // R5
    else begin m_region = 7; m_err = 1; end                 // R6
    m_cache = (m_err == 0 && (m_region == 0 || m_region == 1 || m_region == 3)) ? 1 : 0;
    m_xlate = (m_err == 0 && xen != 0 && (m_region == 0 || m_region == 3)) ? 1 : 0;
    m_paddr = (m_err != 0 || m_xlate != 0) ? 0 : (va % 64'h2000_0000);   // R8, R9
  endtask

  task automatic compare_all();
    check("R11", "in_ready", longint'(in_ready), longint'((m_valid == 0 || out_ready) ? 1 : 0));
    check("R10", "out_valid", longint'(out_valid), longint'(m_valid));
    if (m_valid != 0) begin
      check(m_err != 0 ? "R6" : "R1", "region", longint'(out_region), longint'(m_region));
      check("R6", "addr_err", longint'(out_addr_err), longint'(m_err));
      check("R2", "cacheable", longint'(out_cacheable), longint'(m_cache));
      check("R7", "xlate", longint'(out_xlate), longint'(m_xlate));
      check(m_err != 0 ? "R9" : "R8", "paddr", longint'(out_paddr), m_paddr);
    end
  endtask

  logic [31:0] pick [20];
  int unsigned lcg = 32'h1234_5678;

  function automatic int unsigned next_rand(inout int unsigned s);
    s = s * 32'd1664525 + 32'd1013904223;
    return s;
  endfunction

  initial begin
    // boundary addresses; R4/R5 windows and R6 holes included
    pick = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
             32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
             32'hE000_0000, 32'hE3FF_FFFF, 32'hE400_0000, 32'hE4FF_FFFF,
             32'hE500_0000, 32'hE5FF_FFFF, 32'hE600_0000, 32'hFFFF_FFFF,
             32'h1234_5678, 32'hC765_4321, 32'hE2AB_CDEF, 32'hE5A5_5A5A};
    m_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: after reset no verdict is pending and the stage is open
    check("R12", "out_valid after reset", longint'(out_valid), 0);
    check("R12", "in_ready after reset", longint'(in_ready), 1);
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int cyc = 0; cyc < 240; cyc++) begin
        int unsigned r;
        int accept;
        compare_all();
        r = next_rand(lcg);
        cfg_xlate_en = cfg[0];
        cfg_sq_lock  = cfg[1];
        cfg_ocm_user = cfg[2];
        in_valid  = (r[3:2] != 2'b00);
        out_ready = (cyc >= 40 && cyc < 60) ? 1'b0 : (r[6:4] > 3'd1);   // R11 long stall
        in_priv   = r[7];
        if (cyc < 80) in_vaddr = pick[(cyc / 2) % 20];
        else          in_vaddr = next_rand(lcg);
        accept = (in_valid && (m_valid == 0 || out_ready)) ? 1 : 0;
        if (accept != 0) begin
          predict(longint'(in_vaddr), int'(in_priv), int'(cfg_xlate_en),
                  int'(cfg_sq_lock), int'(cfg_ocm_user));
          m_valid = 1;
        end else if (out_ready) m_valid = 0;
        @(negedge clk);
      end
    end
    compare_all();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule